// File: doc/BRIEF.md
# Three-phase center-aligned PWM generator

This block drives a three-phase inverter bridge with three complementary pairs of active-high gate signals. One up/down counter is shared by all three phases. In the first half of each period it counts down from `half_period-1` to 0. In the second half it counts back up to `half_period-1`. A full period is therefore `2*half_period` clock cycles.

For each phase, a duty value decides how long the high-side switch conducts, centred on the period midpoint. The low-side signal is the complement of the high-side signal, with a dead band removed on both edges. Pulses that are too narrow are removed, and off-gaps that are too narrow are closed.

Around the waveform core there are several controls:
- duty reload at period start only, or at both period start and the midpoint;
- per-pin output enables and per-pair high/low crossover;
- a free-running chopping carrier that can be gated onto the high-side pins, the low-side pins, or both;
- a sync pulse of programmable length for starting ADC conversions.

Two mechanisms shut the outputs off. A software stop halts the generator. An active-low trip input forces every output low through pure gating, so it acts even with no clock. The trip input is also synchronised and latched, and the latch halts the generator until software clears it.

Top module: `pwm3ph_gen`

## Requirements
- R1: While reset is applied, and after reset until the first start, all six gate outputs, `adc_sync` and `stat_second_half` are 0, and `stat_trip` is 1.
- R2: A start runs the period as follows.
  - The first active cycle is period position 0. One period is 2*H cycles, where H is `half_period` sampled at the period-start edge (H must be at least 2).
  - `stat_second_half` is 1 exactly in positions H to 2H-1.
  - `half_period`, `dead_time` and `min_width` take effect only at period start.
- R3: Define the following for one half-period:
  - D is the active duty, clipped to H, and T is the dead time.
  - The high-side on-count is max(D-T,0).
  - The low-side on-count is H-D-T, or 0 if D+T is at least H.
  - The high-side pin is 1 in positions H-on to H+on-1.
  - The low-side pin is 1 in positions below its on-count and in positions at or above 2H minus its on-count.
  - Both pins of a pair are never 1 together.
- R4: When `dbl_mode` is 0, duty inputs are sampled only at the period-start edge. A duty change at any other time has no effect on the outputs until the next period.
- R5: When `dbl_mode` is 1 at the midpoint edge, the duty inputs are also sampled there and govern the second half-period.
- R6: Let M be `min_width`. An on-count below M becomes 0, so the pin stays off for that half. Otherwise, an on-count that leaves an off-gap H-on below M becomes H, so the pin stays on for the whole half.
- R7: `adc_sync` is 1 for `sync_width` cycles starting at position 0. When `dbl_mode` is 1 it also starts at position H; a restart cuts the previous pulse short. A width of 0 gives no pulse.
- R8: `en_hi[p]` and `en_lo[p]` (bit 0 = phase A, 1 = B, 2 = C) each gate one pin. A cleared bit holds that pin at 0.
- R9: When `xover[p]` is 1, pair p's high-side waveform appears on its low-side pin and its low-side waveform on its high-side pin. Crossover is applied before chopping and enables.
- R10: The chopping carrier starts at 0 when reset is released. It toggles every `chop_div`+1 cycles. When `chop_hi_en` or `chop_lo_en` is set, the carrier is ANDed into all high-side pins or all low-side pins respectively.
- R11: Trip behaviour:
  - While `trip_n` is 0, all six gate outputs are 0 in the same cycle.
  - Two edges after `trip_n` goes low, a latch sets and the generator stops.
  - The latch clears only on a `trip_clr` pulse while the synchronised trip level is high.
- R12: Start and stop behaviour:
  - A `sw_stop` pulse stops the generator and drives all outputs low.
  - A `sw_start` pulse restarts it at period start.
  - `sw_start` is ignored while running or while the trip latch is set.
- R13: `stat_trip` shows the level of `trip_n` delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trip_n | input | 1 | Active-low trip, gates outputs combinationally |
| sw_start | input | 1 | One-cycle restart request |
| sw_stop | input | 1 | One-cycle shutdown request |
| trip_clr | input | 1 | One-cycle trip latch clear |
| dbl_mode | input | 1 | 1 = reload duties at midpoint as well |
| half_period | input | CW | Half of the period in cycles (at least 2) |
| dead_time | input | CW | Dead band per edge in cycles |
| min_width | input | CW | Minimum pulse and gap width in cycles |
| sync_width | input | CW | ADC sync pulse length in cycles |
| duty_a | input | CW | Phase A duty (half on-time in cycles) |
| duty_b | input | CW | Phase B duty |
| duty_c | input | CW | Phase C duty |
| en_hi | input | 3 | High-side pin enables, bit p = phase p |
| en_lo | input | 3 | Low-side pin enables, bit p = phase p |
| xover | input | 3 | Per-pair crossover |
| chop_div | input | CHW | Chopping half-cycle length minus one |
| chop_hi_en | input | 1 | Chop the high-side pins |
| chop_lo_en | input | 1 | Chop the low-side pins |
| pwm_hi | output | 3 | High-side gate signals |
| pwm_lo | output | 3 | Low-side gate signals |
| adc_sync | output | 1 | ADC start pulse |
| stat_trip | output | 1 | Synchronised trip level |
| stat_second_half | output | 1 | 1 in the second half-period |

## Verification
The three phases are run with different duty values at the same time: zero, mid-range, exactly H, above H, and values near the dead-time and minimum-width thresholds. This separates clipping, dead-band removal, pulse deletion and full-on holding. Duties are changed at off-boundary instants in both update modes, which distinguishes loading at period start only from loading at the midpoint as well. Enable, crossover and chop patterns are chosen asymmetrically across phases and sides, so a swapped bit or a wrong pin group shows up. Trip, stop and restart are issued mid-period, including restart attempts while the trip latch is still set.

// File: rtl/pwm3ph_pkg.sv
package pwm3ph_pkg;
  localparam int CNT_W_DEF = 16;
  localparam int NPH       = 3;

  // period events decided by the control logic for the next edge
  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_TOP  = 2'd1,
    EV_MID  = 2'd2
  } pev_e;
endpackage

// File: rtl/pwm3ph_timebase.sv
module pwm3ph_timebase
  import pwm3ph_pkg::*;
#(
  parameter int CW = CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          run_d,
  input  pev_e          ev,
  input  logic          dbl,
  input  logic [CW-1:0] hp_in,
  input  logic [CW-1:0] dt_in,
  input  logic [CW-1:0] mw_in,
  input  logic [CW-1:0] sync_w,
  output logic [CW-1:0] cnt,
  output logic          second,
  output logic [CW-1:0] hp_q,
  output logic [CW-1:0] dt_q,
  output logic [CW-1:0] mw_q,
  output logic          sync_o,
  output logic          at_end,
  output logic          at_mid
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, sync_q, sync_d, sync_dec;
  logic          sec_q, sec_d, ld_cfg;

  assign at_end   = active & sec_q & (cnt_q == hp_q - ONE);
  assign at_mid   = active & ~sec_q & (cnt_q == '0);
  assign sync_dec = (sync_q != '0) ? sync_q - ONE : '0;
  assign ld_cfg   = run_d & (ev == EV_TOP);

  always_comb begin
    cnt_d  = cnt_q;
    sec_d  = sec_q;
    sync_d = sync_dec;
    if (!run_d) begin
      cnt_d  = '0;
      sec_d  = 1'b0;
      sync_d = '0;
    end else begin
      unique case (ev)
        EV_TOP: begin
          cnt_d  = hp_in - ONE;
          sec_d  = 1'b0;
          sync_d = sync_w;
        end
        EV_MID: begin
          cnt_d = '0;
          sec_d = 1'b1;
          if (dbl) sync_d = sync_w;
        end
        default: cnt_d = sec_q ? cnt_q + ONE : cnt_q - ONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sec_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sec_q  <= sec_d;
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q <= '0;
      dt_q <= '0;
      mw_q <= '0;
    end else if (ld_cfg) begin
      hp_q <= hp_in;
      dt_q <= dt_in;
      mw_q <= mw_in;
    end
  end

  assign cnt    = cnt_q;
  assign second = sec_q;
  assign sync_o = (sync_q != '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) active |-> (cnt_q < hp_q)); // R2
  AST_SYNC_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n) (run_d && ev == EV_TOP && sync_w != '0) |=> sync_o); // R7
endmodule

// File: rtl/pwm3ph_phase.sv
module pwm3ph_phase
  import pwm3ph_pkg::*;
#(
  parameter int CW = CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pev_e          ev,
  input  logic          dbl,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] hp,
  input  logic [CW-1:0] dt,
  input  logic [CW-1:0] mw,
  output logic          hi_w,
  output logic          lo_w
);
  localparam int XW = CW + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] duty_q;
  logic          ld_duty;
  logic [XW-1:0] hp_x, dt_x, mw_x, d_c, sum_x, hon_r, lon_r, hon, lon, rcnt_x;

  function automatic logic [XW-1:0] width_fix(input logic [XW-1:0] on,
                                              input logic [XW-1:0] span,
                                              input logic [XW-1:0] minw);
    if (on < minw)             return '0;
    else if (span - on < minw) return span;
    else                       return on;
  endfunction

  assign ld_duty = (ev == EV_TOP) | ((ev == EV_MID) & dbl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (ld_duty) duty_q <= duty_in;
  end

  always_comb begin
    hp_x   = {1'b0, hp};
    dt_x   = {1'b0, dt};
    mw_x   = {1'b0, mw};
    d_c    = ({1'b0, duty_q} > hp_x) ? hp_x : {1'b0, duty_q};
    sum_x  = d_c + dt_x;
    hon_r  = (d_c > dt_x) ? d_c - dt_x : '0;
    lon_r  = (sum_x >= hp_x) ? '0 : hp_x - sum_x;
    hon    = width_fix(hon_r, hp_x, mw_x);
    lon    = width_fix(lon_r, hp_x, mw_x);
    rcnt_x = {1'b0, hp - ONE - cnt};
    hi_w   = ({1'b0, cnt} < hon);
    lo_w   = (rcnt_x < lon);
  end

  AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(hi_w && lo_w)); // R3
endmodule

// File: rtl/pwm3ph_chop.sv
module pwm3ph_chop #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  output logic          chop_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          sig_q, sig_d, wrap;

  assign wrap = (cnt_q == div);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + DW'(1);
    sig_d = wrap ? ~sig_q : sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sig_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sig_q <= sig_d;
    end
  end

  assign chop_o = sig_q;

  AST_CHOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt_q != div) |=> $stable(sig_q)); // R10
endmodule

// File: rtl/pwm3ph_outmux.sv
module pwm3ph_outmux #(
  parameter int NP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] hi_w,
  input  logic [NP-1:0] lo_w,
  input  logic [NP-1:0] xover,
  input  logic [NP-1:0] en_hi,
  input  logic [NP-1:0] en_lo,
  input  logic          chop,
  input  logic          chop_hi_en,
  input  logic          chop_lo_en,
  input  logic          gate_ok,
  input  logic          trip_n,
  output logic [NP-1:0] pin_hi,
  output logic [NP-1:0] pin_lo
);
  logic pass;
  logic chop_h, chop_l;

  assign pass   = gate_ok & trip_n;
  assign chop_h = chop_hi_en ? chop : 1'b1;
  assign chop_l = chop_lo_en ? chop : 1'b1;

  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic sw_h, sw_l;
    assign sw_h      = xover[p] ? lo_w[p] : hi_w[p];
    assign sw_l      = xover[p] ? hi_w[p] : lo_w[p];
    assign pin_hi[p] = sw_h & chop_h & en_hi[p] & pass;
    assign pin_lo[p] = sw_l & chop_l & en_lo[p] & pass;
  end

  AST_EN_MASK: assert property (@(posedge clk) disable iff (!rst_n) ((pin_hi & ~en_hi) == '0) && ((pin_lo & ~en_lo) == '0)); // R8
endmodule

// File: rtl/pwm3ph_gen.sv
module pwm3ph_gen
  import pwm3ph_pkg::*;
#(
  parameter int CW  = CNT_W_DEF,
  parameter int CHW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trip_n,
  input  logic           sw_start,
  input  logic           sw_stop,
  input  logic           trip_clr,
  input  logic           dbl_mode,
  input  logic [CW-1:0]  half_period,
  input  logic [CW-1:0]  dead_time,
  input  logic [CW-1:0]  min_width,
  input  logic [CW-1:0]  sync_width,
  input  logic [CW-1:0]  duty_a,
  input  logic [CW-1:0]  duty_b,
  input  logic [CW-1:0]  duty_c,
  input  logic [2:0]     en_hi,
  input  logic [2:0]     en_lo,
  input  logic [2:0]     xover,
  input  logic [CHW-1:0] chop_div,
  input  logic           chop_hi_en,
  input  logic           chop_lo_en,
  output logic [2:0]     pwm_hi,
  output logic [2:0]     pwm_lo,
  output logic           adc_sync,
  output logic           stat_trip,
  output logic           stat_second_half
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic rst_ff1, rst_i_n;
  logic trip_s1, trip_s2, trip_lat, trip_lat_d;
  logic run_q, run_d, stop_now, go;
  logic at_end, at_mid, second, chop;
  logic [CW-1:0] cnt, hp_q, dt_q, mw_q;
  logic [NPH-1:0] hi_w, lo_w;
  logic [CW-1:0] duty_v [NPH];
  pev_e ev;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff1 <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_ff1 <= 1'b1;
      rst_i_n <= rst_ff1;
    end
  end

  always_comb begin
    stop_now   = sw_stop | ~trip_s2;
    go         = sw_start & ~run_q & ~trip_lat & ~stop_now;
    run_d      = ~stop_now & (run_q | go);
    trip_lat_d = ~trip_s2 | (trip_lat & ~trip_clr);
    if (!run_d)             ev = EV_IDLE;
    else if (go || at_end)  ev = EV_TOP;
    else if (at_mid)        ev = EV_MID;
    else                    ev = EV_IDLE;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      trip_s1  <= 1'b1;
      trip_s2  <= 1'b1;
      trip_lat <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      trip_s1  <= trip_n;
      trip_s2  <= trip_s1;
      trip_lat <= trip_lat_d;
      run_q    <= run_d;
    end
  end

  pwm3ph_timebase #(.CW(CW)) u_tb (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .active (run_q),
    .run_d  (run_d),
    .ev     (ev),
    .dbl    (dbl_mode),
    .hp_in  (half_period),
    .dt_in  (dead_time),
    .mw_in  (min_width),
    .sync_w (sync_width),
    .cnt    (cnt),
    .second (second),
    .hp_q   (hp_q),
    .dt_q   (dt_q),
    .mw_q   (mw_q),
    .sync_o (adc_sync),
    .at_end (at_end),
    .at_mid (at_mid)
  );

  pwm3ph_chop #(.DW(CHW)) u_chop (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .div    (chop_div),
    .chop_o (chop)
  );

  assign duty_v[0] = duty_a;
  assign duty_v[1] = duty_b;
  assign duty_v[2] = duty_c;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pwm3ph_phase #(.CW(CW)) u_ph (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .ev      (ev),
      .dbl     (dbl_mode),
      .duty_in (duty_v[p]),
      .cnt     (cnt),
      .hp      (hp_q),
      .dt      (dt_q),
      .mw      (mw_q),
      .hi_w    (hi_w[p]),
      .lo_w    (lo_w[p])
    );
  end

  pwm3ph_outmux #(.NP(NPH)) u_mux (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .hi_w       (hi_w),
    .lo_w       (lo_w),
    .xover      (xover),
    .en_hi      (en_hi),
    .en_lo      (en_lo),
    .chop       (chop),
    .chop_hi_en (chop_hi_en),
    .chop_lo_en (chop_lo_en),
    .gate_ok    (run_q & ~trip_lat),
    .trip_n     (trip_n),
    .pin_hi     (pwm_hi),
    .pin_lo     (pwm_lo)
  );

  assign stat_trip        = trip_s2;
  assign stat_second_half = second;

  AST_TRIP_HALTS: assert property (@(posedge clk) disable iff (!rst_i_n) !trip_s2 |=> !run_q); // R11
  AST_TRIP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_i_n) !trip_n |-> (pwm_hi == 3'b000 && pwm_lo == 3'b000)); // R11
  AST_START_AT_TOP: assert property (@(posedge clk) disable iff (!rst_i_n) $rose(run_q) |-> (!second && cnt == hp_q - ONE)); // R12
  AST_LATCH_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_i_n) (trip_lat && !run_q) |=> !run_q); // R12
endmodule

// File: tb/test_pwm3ph_gen.sv
module test_pwm3ph_gen;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_n = 1'b1, sw_start = 1'b0, sw_stop = 1'b0, trip_clr = 1'b0, dbl_mode = 1'b0;
  logic [CW-1:0] half_period = 16'd20, dead_time = 16'd2, min_width = 16'd3, sync_width = 16'd4;
  logic [CW-1:0] duty_a = 16'd10, duty_b = 16'd5, duty_c = 16'd15;
  logic [2:0] en_hi = 3'b111, en_lo = 3'b111, xover = 3'b000;
  logic [7:0] chop_div = 8'd3;
  logic chop_hi_en = 1'b0, chop_lo_en = 1'b0;
  logic [2:0] pwm_hi, pwm_lo;
  logic adc_sync, stat_trip, stat_second_half;

  always #10 clk = ~clk;

  pwm3ph_gen i_pwm3ph_gen (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .sw_start(sw_start), .sw_stop(sw_stop),
    .trip_clr(trip_clr), .dbl_mode(dbl_mode), .half_period(half_period), .dead_time(dead_time),
    .min_width(min_width), .sync_width(sync_width), .duty_a(duty_a), .duty_b(duty_b),
    .duty_c(duty_c), .en_hi(en_hi), .en_lo(en_lo), .xover(xover), .chop_div(chop_div),
    .chop_hi_en(chop_hi_en), .chop_lo_en(chop_lo_en), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .adc_sync(adc_sync), .stat_trip(stat_trip), .stat_second_half(stat_second_half)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  // reference model state: tick position within the period
  int m_rc, m_t, m_hp, m_dt, m_mw, m_sync, m_chc;
  int m_dty [3];
  bit m_run, m_ts1, m_ts2, m_tlat, m_chs;

  function automatic void m_clear();
    m_t = 0; m_hp = 0; m_dt = 0; m_mw = 0; m_sync = 0; m_chc = 0;
    m_dty[0] = 0; m_dty[1] = 0; m_dty[2] = 0;
    m_run = 0; m_ts1 = 1; m_ts2 = 1; m_tlat = 0; m_chs = 0;
  endfunction

  function automatic int fix_w(int on, int span, int mw);
    if (on < mw) return 0;
    if (span - on < mw) return span;
    return on;
  endfunction

  always @(posedge clk) begin
    bit o_ts2, o_run, o_tlat, stop, go, wrap;
    if (!rst_n) begin
      m_rc = 0;
      m_clear();
    end else if (m_rc < 2) begin
      m_rc++;
      m_clear();
    end else begin
      o_ts2 = m_ts2; o_run = m_run; o_tlat = m_tlat;
      stop = sw_stop || !o_ts2;
      go   = sw_start && !o_run && !o_tlat && !stop;
      wrap = o_run && (m_t == 2 * m_hp - 1);
      m_ts2 = m_ts1;
      m_ts1 = trip_n;
      m_tlat = !o_ts2 || (o_tlat && !trip_clr);
      if (m_chc == int'(chop_div)) begin m_chc = 0; m_chs = !m_chs; end
      else m_chc++;
      if (stop) begin
        m_run = 0; m_sync = 0; m_t = 0;
      end else if (go || wrap) begin
        m_run = 1; m_t = 0;
        m_hp = half_period; m_dt = dead_time; m_mw = min_width;
        m_dty[0] = duty_a; m_dty[1] = duty_b; m_dty[2] = duty_c;
        m_sync = sync_width;
      end else if (o_run) begin
        m_t++;
        if (m_t == m_hp && dbl_mode) begin
          m_dty[0] = duty_a; m_dty[1] = duty_b; m_dty[2] = duty_c;
          m_sync = sync_width;
        end else if (m_sync > 0) m_sync--;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    logic [8:0] exp_v, got_v;
    logic [2:0] eh, el;
    bit gate;
    if (rst_n) begin
      gate = m_run && !m_tlat && trip_n;
      for (int p = 0; p < 3; p++) begin
        int d, hon, lon;
        bit hi, lo, ph, pl;
        d   = (m_dty[p] > m_hp) ? m_hp : m_dty[p];
        hon = fix_w((d > m_dt) ? d - m_dt : 0, m_hp, m_mw);
        lon = fix_w((d + m_dt >= m_hp) ? 0 : m_hp - d - m_dt, m_hp, m_mw);
        hi  = m_run && (m_t >= m_hp - hon) && (m_t < m_hp + hon);
        lo  = m_run && ((m_t < lon) || (m_t >= 2 * m_hp - lon));
        ph  = xover[p] ? lo : hi;
        pl  = xover[p] ? hi : lo;
        if (chop_hi_en) ph = ph && m_chs;
        if (chop_lo_en) pl = pl && m_chs;
        eh[p] = ph && en_hi[p] && gate;
        el[p] = pl && en_lo[p] && gate;
      end
      exp_v = {eh, el, (m_sync != 0), m_ts2, (m_run && m_t >= m_hp)};
      got_v = {pwm_hi, pwm_lo, adc_sync, stat_trip, stat_second_half};
      n_chk++;
      if (got_v !== exp_v) begin
        n_bad++;
        $display("FAIL %s t=%0t {hi,lo,sync,trip,half} got=%b exp=%b", cur_req, $time, got_v, exp_v);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_pulse();
    sw_start = 1'b1; step(1); sw_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    step(3);
    @(negedge clk);
    chk({pwm_hi, pwm_lo, adc_sync, stat_second_half} == 8'h00 && stat_trip, "R1",
        {pwm_hi, pwm_lo, adc_sync, stat_second_half}, 0);
    step(1);
    rst_n = 1'b1;
    step(6);
    chk({pwm_hi, pwm_lo, adc_sync, stat_second_half} == 8'h00, "R1",
        {pwm_hi, pwm_lo, adc_sync, stat_second_half}, 0);

    cur_req = "R2"; start_pulse(); step(100);
    half_period = 16'd12; step(60); half_period = 16'd20; step(50);
    cur_req = "R3"; duty_a = 16'd0; duty_b = 16'd20; duty_c = 16'd25; step(80);
    dead_time = 16'd0; duty_a = 16'd7; duty_b = 16'd13; duty_c = 16'd1; step(80);
    dead_time = 16'd2;
    cur_req = "R4"; step(13); duty_a = 16'd3; step(45); duty_a = 16'd17; step(60);
    cur_req = "R5"; dbl_mode = 1'b1; duty_a = 16'd4; step(27); duty_a = 16'd16; step(33);
    duty_b = 16'd2; step(50); dbl_mode = 1'b0;
    cur_req = "R6"; min_width = 16'd4; duty_a = 16'd5; duty_b = 16'd18; duty_c = 16'd19; step(90);
    min_width = 16'd3;
    cur_req = "R7"; sync_width = 16'd0; step(80); sync_width = 16'd1; step(50);
    dbl_mode = 1'b1; sync_width = 16'd25; step(90); dbl_mode = 1'b0; sync_width = 16'd4; step(10);
    cur_req = "R8"; duty_a = 16'd10; duty_b = 16'd6; duty_c = 16'd14;
    en_hi = 3'b101; en_lo = 3'b010; step(60); en_hi = 3'b111; en_lo = 3'b111;
    cur_req = "R9"; xover = 3'b011; step(60); xover = 3'b000;
    cur_req = "R10"; chop_hi_en = 1'b1; step(50); chop_div = 8'd0; chop_lo_en = 1'b1; step(50);
    chop_div = 8'd5; chop_hi_en = 1'b0; step(50); chop_lo_en = 1'b0;
    cur_req = "R12"; step(7); sw_stop = 1'b1; step(1); sw_stop = 1'b0; step(30);
    chk({pwm_hi, pwm_lo} == 6'd0, "R12", {pwm_hi, pwm_lo}, 0);
    step(3); start_pulse(); step(60); start_pulse(); step(20);
    cur_req = "R11"; step(5); trip_n = 1'b0; #1;
    chk({pwm_hi, pwm_lo} == 6'd0, "R11", {pwm_hi, pwm_lo}, 0);
    cur_req = "R13"; step(2);
    chk(stat_trip == 1'b0, "R13", stat_trip, 0);
    step(10); trip_n = 1'b1; step(5);
    cur_req = "R11"; start_pulse(); step(20);
    chk({pwm_hi, pwm_lo, stat_second_half} == 7'd0, "R11", {pwm_hi, pwm_lo, stat_second_half}, 0);
    trip_clr = 1'b1; step(1); trip_clr = 1'b0;
    cur_req = "R12"; start_pulse(); step(60);
    finish_run();
  end
endmodule